// File: doc/BRIEF.md
# Serial ADC Word Readout Controller

This block is a master that fetches one conversion result from a serial converter. The converter pulls a data-ready line low when a result is waiting. The controller then lowers chip select and waits a programmable setup time. By the end of that wait the converter has already placed the first bit on the data line. After that the controller issues serial clock pulses. The converter changes its data shortly after each falling clock edge, so the controller does not sample on the opposite edge. It waits a programmable number of system clocks after each falling edge and samples then. This places the capture after the worst-case data-valid delay.

The final bit needs its own care. Shortly after the last falling edge the converter stops driving the data line, and the line floats. For that bit the controller uses a separate, shorter sample delay. It compares that delay against a configured float delay and raises a sticky flag if the capture would land too late. A finished word is presented with a one-cycle valid strobe. A cancel request raises chip select at once and ends the transfer with an error pulse.

Top module: `adc_word_reader`

## Requirements
- R1: While reset is high and in the cycle after it, `cs_n` is 1 and `sclk`, `word_valid`, `abort_err` and `timing_viol` are 0.
- R2: A read starts only if `start` is 1 and `drdy_n` is 0 on a clock edge while the block is idle. `cs_n` is 0 from that edge on.
- R3: After `cs_n` falls, `sclk` stays 0 for `cfg_setup`+1 clocks. The first bit (bit 19 of the result) is sampled on the edge that ends this wait, and `sclk` rises on that same edge.
- R4: Each serial clock high phase lasts `cfg_half`+1 clocks. After each sample other than the last, the clock stays low for a further `cfg_half`+1 clocks before it rises again. Exactly 19 pulses are issued per word.
- R5: After each of the first 18 falling edges, the next bit is sampled `cfg_dly`+1 clocks after `sclk` falls. After the 19th falling edge, the last bit (bit 0) is sampled `cfg_last_dly`+1 clocks after the fall. Bits fill `word` from bit 19 down to bit 0.
- R6: On the edge that samples bit 0, `cs_n` returns to 1, `word` takes the result, and `word_valid` is 1 for exactly one cycle.
- R7: A `start` that arrives while a read is in progress has no effect on the sequence.
- R8: If `cancel` is 1 on an edge during a read, the next cycle shows `cs_n`=1, `sclk`=0 and a one-cycle `abort_err`. That read produces no `word_valid`. In idle, `cancel` has no effect.
- R9: If `cfg_last_dly` >= `cfg_tz_dly` when a word completes, `timing_viol` becomes 1. It stays 1 until reset.
- R10: `sclk` is 0 whenever `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Read request |
| drdy_n | input | 1 | Converter result ready, active low |
| cancel | input | 1 | Abort the transfer in progress |
| sdata | input | 1 | Serial data from the converter |
| cfg_half | input | CW | Serial clock phase length minus one, in clocks |
| cfg_setup | input | CW | Chip-select setup wait minus one, in clocks |
| cfg_dly | input | CW | Sample delay minus one for bits 18 to 1 |
| cfg_last_dly | input | CW | Sample delay minus one for bit 0 |
| cfg_tz_dly | input | CW | Float delay of the data line, compared with cfg_last_dly |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| word | output | W | Assembled result |
| word_valid | output | 1 | One-cycle result strobe |
| abort_err | output | 1 | One-cycle abort strobe |
| timing_viol | output | 1 | Sticky last-bit window violation |

## Verification
The main internal risks are a slip in the phase counter or in the bit counter. Either one changes the edge on which `sclk` toggles, so it shows at the ports within one serial clock phase. A bit counter that stops one pulse early or late changes the pulse count and moves the `word_valid` edge. It also shifts the result by one place, and this shows in the word compare. A sample delay applied to the wrong bit moves the low-phase lengths on the clock output. A lost abort path leaves `cs_n` low in the cycle after `cancel`, and this is caught at once.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_WAITS,
    ST_LOW
  } rd_state_t;
endpackage

// File: rtl/adc_rd_timer.sv
// Phase counter: counts from zero, hit when the count equals the limit.
module adc_rd_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic          hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == lim);
endmodule

// File: rtl/adc_rd_shifter.sv
// MSB-first capture register.
module adc_rd_shifter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/adc_word_reader.sv
module adc_word_reader
  import adc_rd_pkg::*;
#(
  parameter int W  = 20,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          drdy_n,
  input  logic          cancel,
  input  logic          sdata,
  input  logic [CW-1:0] cfg_half,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_dly,
  input  logic [CW-1:0] cfg_last_dly,
  input  logic [CW-1:0] cfg_tz_dly,
  output logic          cs_n,
  output logic          sclk,
  output logic [W-1:0]  word,
  output logic          word_valid,
  output logic          abort_err,
  output logic          timing_viol
);
  localparam int PULSES = W - 1;
  localparam int BW     = $clog2(W);

  rd_state_t     state;
  logic [CW-1:0] lim;
  logic          hit;
  logic          clr;
  logic          shift_en;
  logic [W-1:0]  sh;
  logic [BW-1:0] nbits;
  logic          last_bit;
  logic          busy;

  assign busy     = (state != ST_IDLE);
  assign last_bit = (nbits == BW'(PULSES - 1));

  always_comb begin
    case (state)
      ST_SETUP:       lim = cfg_setup;
      ST_HIGH, ST_LOW: lim = cfg_half;
      ST_WAITS:       lim = last_bit ? cfg_last_dly : cfg_dly;
      default:        lim = '0;
    endcase
  end

  assign clr      = !busy || hit || cancel;
  assign shift_en = busy && !cancel && hit &&
                    (state == ST_SETUP || state == ST_WAITS);

  adc_rd_timer #(.CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .lim (lim),
    .hit (hit)
  );

  adc_rd_shifter #(.W(W)) u_shift (
    .clk (clk),
    .rst (rst),
    .en  (shift_en),
    .din (sdata),
    .q   (sh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cs_n        <= 1'b1;
      sclk        <= 1'b0;
      word        <= '0;
      word_valid  <= 1'b0;
      abort_err   <= 1'b0;
      timing_viol <= 1'b0;
      nbits       <= '0;
    end else begin
      word_valid <= 1'b0;
      abort_err  <= 1'b0;
      if (cancel && busy) begin
        state     <= ST_IDLE;
        cs_n      <= 1'b1;
        sclk      <= 1'b0;
        abort_err <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start && !drdy_n) begin
              state <= ST_SETUP;
              cs_n  <= 1'b0;
              nbits <= '0;
            end
          end
          ST_SETUP: begin
            if (hit) begin
              sclk  <= 1'b1;
              state <= ST_HIGH;
            end
          end
          ST_HIGH: begin
            if (hit) begin
              sclk  <= 1'b0;
              state <= ST_WAITS;
            end
          end
          ST_WAITS: begin
            if (hit) begin
              if (last_bit) begin
                state      <= ST_IDLE;
                cs_n       <= 1'b1;
                word       <= {sh[W-2:0], sdata};
                word_valid <= 1'b1;
                if (cfg_last_dly >= cfg_tz_dly) timing_viol <= 1'b1;
              end else begin
                nbits <= nbits + 1'b1;
                state <= ST_LOW;
              end
            end
          end
          ST_LOW: begin
            if (hit) begin
              sclk  <= 1'b1;
              state <= ST_HIGH;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_word_reader_chk.sv
module adc_word_reader_chk #(
  parameter int W  = 20,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          drdy_n,
  input logic          cancel,
  input logic          cs_n,
  input logic          sclk,
  input logic          word_valid,
  input logic          abort_err,
  input logic          timing_viol
);
  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_start_cond_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(start && !drdy_n));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_valid_deselect_R6: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (cs_n && $past(!cs_n)));

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    !(word_valid && abort_err));

  assert_cancel_ends_R8: assert property (@(posedge clk) disable iff (rst)
    (cancel && !cs_n) |=> (cs_n && !sclk && abort_err));

  assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    timing_viol |=> timing_viol);
endmodule

bind adc_word_reader adc_word_reader_chk #(.W(W), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .drdy_n      (drdy_n),
  .cancel      (cancel),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .word_valid  (word_valid),
  .abort_err   (abort_err),
  .timing_viol (timing_viol)
);

// File: tb/test_adc_word_reader.sv
`timescale 1ns/1ps
module test_adc_word_reader;
  localparam int W  = 20;
  localparam int CW = 8;

  typedef struct {
    bit cs;
    bit sck;
    bit v;
    bit e;
    bit vs;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          drdy_n = 1'b1;
  logic          cancel = 1'b0;
  logic          sdata = 1'b0;
  logic [CW-1:0] cfg_half = '0, cfg_setup = '0, cfg_dly = '0;
  logic [CW-1:0] cfg_last_dly = '0, cfg_tz_dly = 8'd1;
  logic          cs_n, sclk, word_valid, abort_err, timing_viol;
  logic [W-1:0]  word;

  int        checks = 0;
  int        errors = 0;
  exp_t      q[$];
  bit        viol_exp = 0;
  logic [W-1:0] adc_word = '0;
  logic [W-1:0] exp_word = '0;
  int        idx = 0;
  bit        prev_cs = 1, prev_sck = 0;

  always #2.5 clk = ~clk;

  adc_word_reader #(.W(W), .CW(CW)) i_adc_word_reader (
    .clk(clk), .rst(rst), .start(start), .drdy_n(drdy_n), .cancel(cancel),
    .sdata(sdata), .cfg_half(cfg_half), .cfg_setup(cfg_setup),
    .cfg_dly(cfg_dly), .cfg_last_dly(cfg_last_dly), .cfg_tz_dly(cfg_tz_dly),
    .cs_n(cs_n), .sclk(sclk), .word(word), .word_valid(word_valid),
    .abort_err(abort_err), .timing_viol(timing_viol)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic push(input bit cs, input bit sck, input bit v, input bit e, input bit vs);
    exp_t x;
    x.cs = cs; x.sck = sck; x.v = v; x.e = e; x.vs = vs;
    q.push_back(x);
  endtask

  // Expected output timeline of one full read, one entry per clock.
  task automatic push_txn();
    int d;
    for (int i = 0; i <= int'(cfg_setup); i++) push(0, 0, 0, 0, 0);
    for (int b = 0; b < W - 1; b++) begin
      for (int i = 0; i <= int'(cfg_half); i++) push(0, 1, 0, 0, 0);
      d = (b == W - 2) ? int'(cfg_last_dly) : int'(cfg_dly);
      for (int i = 0; i <= d; i++) push(0, 0, 0, 0, 0);
      if (b < W - 2)
        for (int i = 0; i <= int'(cfg_half); i++) push(0, 0, 0, 0, 0);
    end
    push(1, 0, 1, 0, cfg_last_dly >= cfg_tz_dly);
    exp_word = adc_word;
  endtask

  task automatic step(input bit st, input bit cn);
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin e.cs = 1; e.sck = 0; e.v = 0; e.e = 0; e.vs = 0; end
    if (e.vs) viol_exp = 1;
    chk(cs_n === e.cs, "R3 cs_n", 32'(cs_n), 32'(e.cs));
    chk(sclk === e.sck, "R4 sclk", 32'(sclk), 32'(e.sck));
    chk(word_valid === e.v, "R6 word_valid", 32'(word_valid), 32'(e.v));
    chk(abort_err === e.e, "R8 abort_err", 32'(abort_err), 32'(e.e));
    chk(timing_viol === viol_exp, "R9 timing_viol", 32'(timing_viol), 32'(viol_exp));
    chk(!(cs_n && sclk), "R10 sclk idle", 32'(sclk), 32'd0);
    if (e.v) chk(word === exp_word, "R5 word", 32'(word), 32'(exp_word));
    // Converter model: first bit on select, next bit after each falling edge.
    if (prev_cs && !cs_n) begin
      idx = W - 1; sdata = adc_word[idx];
    end else if (prev_sck && !sclk && !cs_n && idx > 0) begin
      idx--; sdata = adc_word[idx];
    end
    prev_cs = cs_n; prev_sck = sclk;
    start = st; cancel = cn;
    if (cn && q.size() > 0) begin
      q.delete();
      push(1, 0, 0, 1, 0);
    end else if (st && !drdy_n && q.size() == 0) begin
      push_txn();
    end
  endtask

  task automatic set_cfg(input int h, input int s, input int d, input int l, input int t);
    cfg_half = CW'(h); cfg_setup = CW'(s); cfg_dly = CW'(d);
    cfg_last_dly = CW'(l); cfg_tz_dly = CW'(t);
  endtask

  task automatic run_word(input logic [W-1:0] w, input bit pokes);
    int n;
    adc_word = w;
    drdy_n = 1'b0;
    step(1, 0);
    n = 0;
    while (q.size() > 0) begin
      n++;
      // R7: extra requests while busy must not disturb the timeline.
      step(pokes && (n % 7 == 3), 0);
    end
    drdy_n = 1'b1;
    repeat (3) step(0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 0; cancel = 0;
    q.delete(); viol_exp = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs_n === 1'b1 && sclk === 1'b0 && word_valid === 1'b0 &&
        abort_err === 1'b0 && timing_viol === 1'b0, "R1 reset outputs",
        {27'd0, cs_n, sclk, word_valid, abort_err, timing_viol}, 32'h10);
    rst = 1'b0;
    prev_cs = 1; prev_sck = 0;
    step(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();

    // R2: request while data not ready is ignored.
    drdy_n = 1'b1;
    step(1, 0);
    repeat (4) step(0, 0);
    chk(cs_n === 1'b1, "R2 no start without ready", 32'(cs_n), 32'd1);

    // R3 R4 R5 R6 with distinct timings and patterns, R7 pokes.
    set_cfg(1, 2, 1, 0, 2);
    run_word(20'hA5C3E, 1);
    set_cfg(0, 0, 0, 0, 1);
    run_word(20'h80001, 0);
    set_cfg(3, 5, 2, 1, 4);
    run_word(20'h7FFFE, 1);
    chk(timing_viol === 1'b0, "R9 no violation yet", 32'(timing_viol), 32'd0);

    // R8: cancel mid-word, and cancel during setup.
    set_cfg(1, 1, 1, 0, 2);
    adc_word = 20'h3C3C3; drdy_n = 1'b0;
    step(1, 0);
    repeat (30) step(0, 0);
    step(0, 1);
    repeat (4) step(0, 0);
    step(1, 0);
    step(0, 1);
    drdy_n = 1'b1;
    repeat (4) step(0, 0);
    chk(cs_n === 1'b1, "R8 deselected after cancel", 32'(cs_n), 32'd1);
    // R8: cancel while idle has no effect.
    step(0, 1);
    repeat (3) step(0, 0);

    // R9: last-bit delay reaching the float delay sets the sticky flag.
    set_cfg(1, 1, 2, 3, 3);
    run_word(20'h12345, 0);
    set_cfg(1, 1, 2, 0, 3);
    run_word(20'hEDCBA, 0);
    chk(timing_viol === 1'b1, "R9 sticky", 32'(timing_viol), 32'd1);

    // R1: reset clears the sticky flag.
    do_reset();
    summary();
  end
endmodule